// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block conditions one input pin. It takes a pad level that has already been synchronized into the core clock domain. It then decides when a change of that level may reach the filtered output, which downstream logic reads as the pin's status and uses to detect interrupts. Time is measured in ticks of a slow timebase. The tick arrives as a single-cycle enable in the core clock domain.

Three configuration fields set the filter. A two-bit mode selects bypass or one of three glitch policies. A two-bit unit select picks how many ticks make one unit. A four-bit count sets how many units a new level must hold. The qualification interval is count × unit ticks. A count of zero gives the shortest possible interval.

The mode decides which direction is filtered. Both-edge filtering suppresses short pulses of either polarity. The two one-sided policies let pulses of one polarity through immediately and qualify only changes in the other direction.

Top module: `pin_debounce`

## Requirements
- R1: The reset is synchronous and active low. While rst_n is low, pin_level loads pin_in at every clock and the stability counter is held idle. After release, the first filtered change needs the full interval.
- R2: Mode 2'b00 is bypass. pin_level takes the value of pin_in one clock later, whatever the tick and the other fields.
- R3: Mode 2'b11 filters both edges. pin_level changes only to the value pin_in holds, and only after pin_in has differed from pin_level for the full interval.
- R4: The interval is cfg_count × U ticks. U is 2, 8, 512 or 2048 for cfg_unit = 0, 1, 2 or 3. pin_level changes at the clock edge that counts the last tick of the interval.
- R5: If pin_in returns to the pin_level value before the interval ends, the stability counter clears. A later change starts a fresh interval.
- R6: Mode 2'b01 lets low pulses through. A falling pin_in appears on pin_level one clock later. A rising pin_in must be qualified for the full interval.
- R7: Mode 2'b10 lets high pulses through. A rising pin_in appears on pin_level one clock later. A falling pin_in must be qualified for the full interval.
- R8: With a filtering mode and cfg_count = 0, the interval is a single tick, whatever cfg_unit is.
- R9: Any change of cfg_mode, cfg_unit or cfg_count clears the stability counter in the clock where the new value is first seen. Counting restarts from the next clock.
- R10: Clocks without a tick do not advance the stability counter, so a filtered change never completes without ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle enable from the slow timebase |
| pin_in | input | 1 | Synchronized raw pad level |
| cfg_mode | input | 2 | Filter policy: 00 bypass, 01 pass lows, 10 pass highs, 11 filter both |
| cfg_unit | input | 2 | Unit select: 2, 8, 512 or 2048 ticks |
| cfg_count | input | COUNT_W | Number of units a new level must hold |
| pin_level | output | 1 | Filtered pin level |

## Verification
The assertions check these rules on every cycle:
- In bypass, the output takes the input's value one clock later.
- The output can only move to the value the input held in the previous clock.
- A one-sided policy passes its pass-through edge one clock later.
- In both-edge mode, the output holds in any clock without a tick.
- With a zero count, a single tick qualifies the change.

The rest is shown only by the bench's timed scenarios. This covers the exact interval length for each unit select and count, the restart after a reversal, and the restart after a configuration change. It also covers how reset interacts with the first interval.

// File: rtl/pin_debounce_pkg.sv
package pin_debounce_pkg;

    // Filter policy encoding; the values are decoded by the configuration field.
    typedef enum logic [1:0] {
        DB_BYPASS      = 2'b00,
        DB_PASS_LOW    = 2'b01,
        DB_PASS_HIGH   = 2'b10,
        DB_FILTER_BOTH = 2'b11
    } db_mode_e;

    // Default tick counts of the four unit selections.
    localparam int unsigned DB_UNIT0_TICKS = 2;
    localparam int unsigned DB_UNIT1_TICKS = 8;
    localparam int unsigned DB_UNIT2_TICKS = 512;
    localparam int unsigned DB_UNIT3_TICKS = 2048;

endpackage

// File: rtl/pin_debounce_policy.sv
// Decides, from the policy and the current disagreement, whether a change
// is passed at once, must be qualified, or the filter is bypassed.
module pin_debounce_policy
    import pin_debounce_pkg::*;
(
    input  db_mode_e mode,
    input  logic     level_q,
    input  logic     pin,
    output logic     bypass,
    output logic     immediate,
    output logic     qualify
);
    logic differ;

    always_comb begin
        differ    = (pin != level_q);
        bypass    = (mode == DB_BYPASS);
        immediate = differ &&
                    (((mode == DB_PASS_LOW)  && !pin) ||
                     ((mode == DB_PASS_HIGH) &&  pin));
        qualify   = differ && !bypass && !immediate;
    end
endmodule

// File: rtl/pin_debounce_prescale.sv
// Counts slow ticks inside one unit and pulses unit_done on the last one.
module pin_debounce_prescale #(
    parameter int unsigned UNIT0_TICKS = 2,
    parameter int unsigned UNIT1_TICKS = 8,
    parameter int unsigned UNIT2_TICKS = 512,
    parameter int unsigned UNIT3_TICKS = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic       restart,
    input  logic       single,
    input  logic [1:0] unit_sel,
    output logic       unit_done
);
    localparam int unsigned MAX_TICKS =
        (UNIT3_TICKS > UNIT2_TICKS) ? UNIT3_TICKS : UNIT2_TICKS;
    localparam int unsigned PRE_W = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] last_idx;

    always_comb begin
        if (single) begin
            last_idx = '0;
        end else begin
            case (unit_sel)
                2'd0:    last_idx = PRE_W'(UNIT0_TICKS - 1);
                2'd1:    last_idx = PRE_W'(UNIT1_TICKS - 1);
                2'd2:    last_idx = PRE_W'(UNIT2_TICKS - 1);
                default: last_idx = PRE_W'(UNIT3_TICKS - 1);
            endcase
        end

        unit_done = run && !restart && tick && (pre_q == last_idx);

        pre_d = pre_q;
        if (!run || restart) begin
            pre_d = '0;
        end else if (tick) begin
            pre_d = unit_done ? '0 : pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
    import pin_debounce_pkg::*;
#(
    parameter int unsigned COUNT_W     = 4,
    parameter int unsigned UNIT0_TICKS = DB_UNIT0_TICKS,
    parameter int unsigned UNIT1_TICKS = DB_UNIT1_TICKS,
    parameter int unsigned UNIT2_TICKS = DB_UNIT2_TICKS,
    parameter int unsigned UNIT3_TICKS = DB_UNIT3_TICKS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               pin_in,
    input  logic [1:0]         cfg_mode,
    input  logic [1:0]         cfg_unit,
    input  logic [COUNT_W-1:0] cfg_count,
    output logic               pin_level
);
    localparam int unsigned CFG_W = 4 + COUNT_W;

    typedef struct packed {
        logic               level;
        logic [COUNT_W-1:0] units;
        logic [CFG_W-1:0]   cfg;
    } db_state_t;

    db_state_t st_d, st_q;

    db_mode_e           mode;
    logic [CFG_W-1:0]   cfg_now;
    logic               cfg_change;
    logic               zero_count;
    logic [COUNT_W-1:0] target;
    logic               bypass, immediate, qualify, unit_done;

    assign mode       = db_mode_e'(cfg_mode);
    assign cfg_now    = {cfg_mode, cfg_unit, cfg_count};
    assign cfg_change = (cfg_now != st_q.cfg);
    assign zero_count = (cfg_count == '0);
    assign target     = zero_count ? COUNT_W'(1) : cfg_count;

    pin_debounce_policy i_policy (
        .mode      (mode),
        .level_q   (st_q.level),
        .pin       (pin_in),
        .bypass    (bypass),
        .immediate (immediate),
        .qualify   (qualify)
    );

    pin_debounce_prescale #(
        .UNIT0_TICKS (UNIT0_TICKS),
        .UNIT1_TICKS (UNIT1_TICKS),
        .UNIT2_TICKS (UNIT2_TICKS),
        .UNIT3_TICKS (UNIT3_TICKS)
    ) i_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (qualify),
        .restart   (cfg_change),
        .single    (zero_count),
        .unit_sel  (cfg_unit),
        .unit_done (unit_done)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cfg = cfg_now;
        if (!rst_n || bypass || immediate) begin
            st_d.level = pin_in;
            st_d.units = '0;
        end else if (!qualify || cfg_change) begin
            st_d.units = '0;
        end else if (unit_done) begin
            if (st_q.units + COUNT_W'(1) == target) begin
                st_d.level = pin_in;
                st_d.units = '0;
            end else begin
                st_d.units = st_q.units + COUNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pin_level = st_q.level;
endmodule

// File: rtl/pin_debounce_chk.sv
module pin_debounce_chk #(
    parameter int unsigned COUNT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               pin_in,
    input logic [1:0]         cfg_mode,
    input logic [1:0]         cfg_unit,
    input logic [COUNT_W-1:0] cfg_count,
    input logic               pin_level
);
    p_bypass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b00) |=> (pin_level == $past(pin_in)));

    p_toward_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_level) |-> (pin_level == $past(pin_in)));

    p_low_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b01 && pin_level && !pin_in) |=> !pin_level);

    p_high_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b10 && !pin_level && pin_in) |=> pin_level);

    p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b11 && cfg_count == '0 && tick && pin_level != pin_in
         && $stable(cfg_mode) && $stable(cfg_unit) && $stable(cfg_count))
        |=> (pin_level == $past(pin_in)));

    p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b11 && !tick) |=> $stable(pin_level));
endmodule

bind pin_debounce pin_debounce_chk #(.COUNT_W(COUNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .pin_in    (pin_in),
    .cfg_mode  (cfg_mode),
    .cfg_unit  (cfg_unit),
    .cfg_count (cfg_count),
    .pin_level (pin_level)
);

// File: tb/test_pin_debounce.sv
module test_pin_debounce;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       pin_in;
    logic [1:0] cfg_mode;
    logic [1:0] cfg_unit;
    logic [3:0] cfg_count;
    logic       pin_level;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pin_debounce i_pin_debounce (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pin_in    (pin_in),
        .cfg_mode  (cfg_mode),
        .cfg_unit  (cfg_unit),
        .cfg_count (cfg_count),
        .pin_level (pin_level)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s at cycle %0d: got %0b expected %0b", tag, cyc, got, exp);
        end
    endtask

    task automatic expect_at(input int due, input logic val, input string tag);
        exp_t e;
        e.due = due; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [1:0] u, input logic [3:0] k);
        cfg_mode = m; cfg_unit = u; cfg_count = k;
        repeat (2) @(negedge clk);
    endtask

    // Drive a new level; expect the old level until n edges pass.
    task automatic step(input logic v, input int n, input string tag);
        int c;
        c = cyc;
        pin_in = v;
        if (n > 1) expect_at(c + n - 1, ~v, tag);
        expect_at(c + n, v, tag);
        drain();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: compares the output against due expectations.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                if (e.due < cyc) begin
                    checks++; failures++;
                    $display("FAIL %s missed slot: got %0b expected %0b", e.tag, pin_level, e.val);
                end else begin
                    check(e.tag, pin_level, e.val);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int c;
        rst_n = 1'b0; tick = 1'b1; pin_in = 1'b1;
        cfg_mode = 2'b11; cfg_unit = 2'd0; cfg_count = 4'd1;
        repeat (3) @(negedge clk);
        check("R1 reset loads input high", pin_level, 1'b1);
        pin_in = 1'b0;
        @(negedge clk);
        check("R1 reset loads input low", pin_level, 1'b0);
        // Release and change together: full interval (2 ticks) still needed.
        rst_n = 1'b1;
        step(1'b1, 2, "R1 first interval after reset");
        step(1'b0, 2, "R1 fall after reset");

        // R3/R4 both-edge, unit0 count3 -> 6 ticks
        set_cfg(2'b11, 2'd0, 4'd3);
        step(1'b1, 6, "R3 rise unit0 x3");
        step(1'b0, 6, "R3 fall unit0 x3");
        set_cfg(2'b11, 2'd1, 4'd2);
        step(1'b1, 16, "R4 unit1 x2");
        set_cfg(2'b11, 2'd2, 4'd1);
        step(1'b0, 512, "R4 unit2 x1");
        set_cfg(2'b11, 2'd3, 4'd1);
        step(1'b1, 2048, "R4 unit3 x1");
        step(1'b0, 2048, "R4 unit3 fall");

        // R5 reversal restarts the count
        set_cfg(2'b11, 2'd0, 4'd3);
        c = cyc;
        pin_in = 1'b1;
        expect_at(c + 4, 1'b0, "R5 inside window");
        repeat (4) @(negedge clk);
        pin_in = 1'b0;
        expect_at(c + 5, 1'b0, "R5 reversal holds");
        @(negedge clk);
        step(1'b1, 6, "R5 fresh interval");

        // R6 pass lows (level is 1)
        set_cfg(2'b01, 2'd0, 4'd3);
        step(1'b0, 1, "R6 fall passes");
        step(1'b1, 6, "R6 rise qualified");
        c = cyc;
        pin_in = 1'b0;
        expect_at(c + 1, 1'b0, "R6 low glitch passes");
        @(negedge clk);
        step(1'b1, 6, "R6 recover after glitch");

        // R7 pass highs
        set_cfg(2'b10, 2'd0, 4'd3);
        step(1'b0, 6, "R7 fall qualified");
        step(1'b1, 1, "R7 rise passes");
        step(1'b0, 6, "R7 fall qualified again");

        // R2 bypass, no ticks
        set_cfg(2'b00, 2'd3, 4'd15);
        tick = 1'b0;
        step(1'b1, 1, "R2 bypass rise");
        step(1'b0, 1, "R2 bypass fall");
        tick = 1'b1;

        // R8 zero count, large unit ignored
        set_cfg(2'b11, 2'd3, 4'd0);
        step(1'b1, 1, "R8 zero count rise");
        step(1'b0, 1, "R8 zero count fall");

        // R9 configuration change restarts counting
        set_cfg(2'b11, 2'd0, 4'd4);
        c = cyc;
        pin_in = 1'b1;
        repeat (5) @(negedge clk);
        cfg_count = 4'd3;
        expect_at(c + 8, 1'b0, "R9 old interval not honoured");
        expect_at(c + 11, 1'b0, "R9 restarted");
        expect_at(c + 12, 1'b1, "R9 new interval done");
        drain();

        // R10 no ticks, no progress
        set_cfg(2'b11, 2'd0, 4'd1);
        tick = 1'b0;
        c = cyc;
        pin_in = 1'b0;
        expect_at(c + 10, 1'b1, "R10 held without ticks");
        repeat (10) @(negedge clk);
        tick = 1'b1;
        expect_at(c + 11, 1'b1, "R10 one tick in");
        expect_at(c + 12, 1'b0, "R10 completes with ticks");
        drain();

        finish_run();
    end
endmodule